// File: doc/BRIEF.md
# Event Counter with Interrupt Arbitration

This block is the timer/event counter slice of a small microcontroller core. It holds an 8-bit count that advances on rising edges of an external test pin once software has issued a start-count command. That command both enables counting and routes the pin to the counter. The pin is brought into the clock domain by a two-stage synchronizer. A rate limiter then admits at most one edge per window of three instruction-cycle strobes. Any edge that arrives inside the window is dropped. Nothing ever forces the count to move, so it may sit on one value for as long as the pin stays quiet.

When the count passes from FFh back to 00h, a timer request latches. An enable bit decides whether that latched request is shown to the arbiter. The arbiter compares it with the external interrupt line, which is also gated by its own enable. The external line always wins, and the block presents the winner's vector address: 3 for the external source and 7 for the timer. The core acknowledges a taken timer request with a one-cycle pulse. Software can preload FFh so that a single rising edge on the test pin raises vector 7. This gives the pin the role of a second external interrupt.

Top module: `evtcnt_irq_top`

## Requirements
- R1: After reset, count_o is 00h, irq_o is 0, vec_o is 0 and counting is disabled, so edges on test_i do not change the count.
- R2: After a start_i pulse, each low-to-high change of test_i adds one to count_o. The change appears on count_o three clock edges after test_i rises, because it passes two synchronizer stages and one edge register. High-to-low changes never count.
- R3: Once an edge is counted, the next edge is accepted only after three cycles in which cyc_stb_i is high. Edges that arrive inside that window are dropped and are not remembered.
- R4: Between accepted edges, count_o holds its value for any length of time.
- R5: stop_i disables counting from the cycle in which it is high and leaves count_o unchanged. load_i writes load_val_i into count_o whether the counter is running or stopped. When a load and an accepted edge fall in the same cycle, the load wins and the edge is lost. When start_i and stop_i are high together, stop_i wins.
- R6: An accepted edge at count FFh wraps the count to 00h and latches a timer request, whatever the value of tmr_ien_i. The latched request is presented (irq_o=1, vec_o=7) only while tmr_ien_i is 1.
- R7: While ext_irq_i and ext_ien_i are both 1, irq_o is 1 and vec_o is 3.
- R8: When both sources are presented, vec_o is 3. The timer request stays latched and shows vec_o=7 once the external source is gone.
- R9: ack_i clears the latched timer request only in a cycle where vec_o is 7. An ack_i while vec_o is 3 leaves the timer request latched.
- R10: stop_i clears a latched timer request.
- R11: With FFh loaded, tmr_ien_i at 1 and counting started, the next rising edge on test_i yields irq_o=1 and vec_o=7.
- R12: When no source is presented, irq_o is 0 and vec_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_stb_i | input | 1 | One-clock strobe per instruction cycle |
| start_i | input | 1 | Start-count command: routes the test pin to the counter and enables it |
| stop_i | input | 1 | Stop command: disables counting and clears the timer request |
| load_i | input | 1 | Write load_val_i into the count |
| load_val_i | input | 8 | Value to load |
| count_o | output | 8 | Current count |
| tmr_ien_i | input | 1 | Timer interrupt enable |
| test_i | input | 1 | Asynchronous test pin used as the event input |
| ext_irq_i | input | 1 | External interrupt request level |
| ext_ien_i | input | 1 | External interrupt enable |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| irq_o | output | 1 | An enabled request is presented |
| vec_o | output | 12 | Vector address of the winner (3 or 7), 0 when idle |

## Verification
The counter is driven with isolated, widely spaced pulses, which separate rising from falling edge counting and show the three-edge latency. It is also driven with bursts of edges faster than the three-strobe window, under strobes that are either constant or sparse, which tells a correct drop window from one that is too short or that remembers edges. Long idle stretches, loads and stops issued while edges are arriving, and preloads of FEh and FFh place the overflow exactly where the timer request must latch and where arbitration against a level-held external request decides the vector. Acknowledges are given to each winner in turn, which separates clearing the timer request from leaving it latched.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned VEC_W   = 12;
  localparam int unsigned RATE    = 3;
  localparam int unsigned VEC_EXT = 3;
  localparam int unsigned VEC_TMR = 7;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_EXT  = 2'd1,
    WIN_TMR  = 2'd2
  } win_e;
endpackage

// File: rtl/evtcnt_edge_qual.sv
module evtcnt_edge_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RATE        = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_stb_i,
  input  logic run_i,
  input  logic stop_i,
  input  logic test_i,
  output logic accept_o
);
  localparam int unsigned GAP_W = $clog2(RATE + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [GAP_W-1:0]       gap_q, gap_d;
  logic                   rise;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[gi] <= 1'b0;
          else         sync_q[gi] <= test_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[gi] <= 1'b0;
          else         sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise     = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign accept_o = run_i & ~stop_i & rise & (gap_q == '0);

  always_comb begin
    gap_d = gap_q;
    if (accept_o)                     gap_d = GAP_W'(RATE);
    else if (cyc_stb_i && gap_q != '0) gap_d = gap_q - GAP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else         gap_q <= gap_d;
  end

  // an accepted edge always opens a full window
  p_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> gap_q == GAP_W'(RATE));
  // the window never moves without a strobe
  p_window_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_stb_i && gap_q != '0) |=> gap_q == $past(gap_q));
endmodule

// File: rtl/evtcnt_count.sv
module evtcnt_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (inc_i) cnt_d = cnt_q + W'(1);
  end

  assign ovf_o   = inc_i & ~load_i & (cnt_q == ALL_ONES);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // with neither load nor increment, the count holds
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> cnt_q == $past(cnt_q));
  // overflow leaves a zero count
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == '0);
endmodule

// File: rtl/evtcnt_arb.sv
module evtcnt_arb
  import evtcnt_pkg::*;
#(
  parameter int unsigned VW   = 12,
  parameter int unsigned VEXT = 3,
  parameter int unsigned VTMR = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ovf_i,
  input  logic          stop_i,
  input  logic          ack_i,
  input  logic          tmr_ien_i,
  input  logic          ext_irq_i,
  input  logic          ext_ien_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  output logic          tmr_pend_o
);
  logic pend_q, pend_d;
  logic ext_req, tmr_req;
  win_e win;

  assign ext_req = ext_irq_i & ext_ien_i;
  assign tmr_req = pend_q & tmr_ien_i;

  always_comb begin
    if (ext_req)      win = WIN_EXT;
    else if (tmr_req) win = WIN_TMR;
    else              win = WIN_NONE;
  end

  always_comb begin
    unique case (win)
      WIN_EXT: vec_o = VW'(VEXT);
      WIN_TMR: vec_o = VW'(VTMR);
      default: vec_o = '0;
    endcase
  end
  assign irq_o = (win != WIN_NONE);

  always_comb begin
    pend_d = pend_q;
    if (ovf_i)                         pend_d = 1'b1;
    else if (stop_i)                   pend_d = 1'b0;
    else if (ack_i && win == WIN_TMR)  pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end
  assign tmr_pend_o = pend_q;

  p_ovf_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> pend_q);
  p_loser_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && ext_req && !stop_i) |=> pend_q);
  p_ack_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && vec_o == VW'(VTMR) && !ovf_i) |=> !pend_q);
  p_stop_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !ovf_i) |=> !pend_q);
  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0);
endmodule

// File: rtl/evtcnt_irq_top.sv
module evtcnt_irq_top
  import evtcnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_stb_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  input  logic             tmr_ien_i,
  input  logic             test_i,
  input  logic             ext_irq_i,
  input  logic             ext_ien_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       run_q, run_d;
  logic       accept;
  logic       ovf;
  logic       tmr_pend;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    run_d = run_q;
    if (stop_i)       run_d = 1'b0;
    else if (start_i) run_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  evtcnt_edge_qual #(.SYNC_STAGES(2), .RATE(RATE)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_n), .cyc_stb_i(cyc_stb_i), .run_i(run_q),
    .stop_i(stop_i), .test_i(test_i), .accept_o(accept)
  );

  evtcnt_count #(.W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_n), .load_i(load_i), .load_val_i(load_val_i),
    .inc_i(accept), .count_o(count_o), .ovf_o(ovf)
  );

  evtcnt_arb #(.VW(VEC_W), .VEXT(VEC_EXT), .VTMR(VEC_TMR)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_n), .ovf_i(ovf), .stop_i(stop_i),
    .ack_i(ack_i), .tmr_ien_i(tmr_ien_i), .ext_irq_i(ext_irq_i),
    .ext_ien_i(ext_ien_i), .irq_o(irq_o), .vec_o(vec_o),
    .tmr_pend_o(tmr_pend)
  );

  // two counts never land on adjacent clocks
  p_rate_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (count_o == $past(count_o) + CNT_W'(1) && !$past(load_i))
      |=> (count_o == $past(count_o) || $past(load_i)));
  // a stop freezes the count unless it is loaded
  p_stop_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stop_i && !load_i) |=> count_o == $past(count_o));
  // the timer request rises only as the count reaches zero
  p_rise_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(tmr_pend) |-> count_o == '0);
  p_ext_vec_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ext_irq_i && ext_ien_i) |-> (irq_o && vec_o == VEC_W'(VEC_EXT)));
endmodule

// File: tb/evtcnt_irq_top_tb.sv
module evtcnt_irq_top_tb;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 0, start = 0, stop = 0, load = 0, tien = 0, test = 0;
  logic ext = 0, eien = 0, ack = 0;
  logic [7:0]  lval = 0;
  logic [7:0]  count;
  logic        irq;
  logic [11:0] vec;

  int total = 0, bad = 0;

  // bench model state
  logic m_s1 = 0, m_s2 = 0, m_s3 = 0, m_run = 0, m_tp = 0;
  logic [7:0] m_cnt = 0;
  int m_gap = 0;

  always #(CLK_NS/2) clk = ~clk;

  evtcnt_irq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_stb_i(stb), .start_i(start),
    .stop_i(stop), .load_i(load), .load_val_i(lval), .count_o(count),
    .tmr_ien_i(tien), .test_i(test), .ext_irq_i(ext), .ext_ien_i(eien),
    .ack_i(ack), .irq_o(irq), .vec_o(vec)
  );

  function automatic int exp_vec(logic tp);
    if (ext && eien) return 3;
    if (tp && tien)  return 7;
    return 0;
  endfunction

  task automatic chk(int act, int exp, string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic tw, rise, acc, ovf;
    tw   = m_tp && tien && !(ext && eien);
    rise = m_s2 && !m_s3;
    acc  = m_run && !stop && rise && (m_gap == 0);
    ovf  = acc && !load && (m_cnt == 8'hFF);
    if (ovf)            m_tp = 1;
    else if (stop)      m_tp = 0;
    else if (ack && tw) m_tp = 0;
    if (load)     m_cnt = lval;
    else if (acc) m_cnt = m_cnt + 8'd1;
    if (acc)                    m_gap = 3;
    else if (stb && m_gap != 0) m_gap = m_gap - 1;
    if (stop)       m_run = 0;
    else if (start) m_run = 1;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = test;
  endtask

  task automatic compare(string tag);
    chk(count, m_cnt, {tag, " count"});
    chk(vec, exp_vec(m_tp), {tag, " vec"});
    chk(irq, exp_vec(m_tp) != 0, {tag, " irq"});
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
    start = 0; stop = 0; load = 0; ack = 0;
  endtask

  task automatic steps(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic pulse(int hi, int lo, string tag);
    test = 1; steps(hi, tag);
    test = 0; steps(lo, tag);
  endtask

  initial begin : watchdog
    #(CLK_NS * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1;
    steps(4, "R1 idle");
    // R1: reset state, edges ignored before start
    chk(count, 0, "R1 count"); chk(irq, 0, "R1 irq"); chk(vec, 0, "R1 vec");
    stb = 1;
    pulse(3, 6, "R1 no start");
    chk(count, 0, "R1 edge before start");

    // R2: start, isolated pulses, latency of three edges
    start = 1; step("R2 start");
    test = 1;
    step("R2 lat"); step("R2 lat");
    chk(count, 0, "R2 not yet");
    step("R2 lat");
    chk(count, 1, "R2 third edge");
    steps(6, "R2 high");
    test = 0; steps(6, "R2 fall");
    chk(count, 1, "R2 falling not counted");
    pulse(2, 6, "R2"); pulse(2, 6, "R2");
    chk(count, 3, "R2 three pulses");

    // R3: fast edges with constant strobe, then sparse strobe
    held = count;
    for (int i = 0; i < 6; i++) pulse(1, 1, "R3 fast");
    steps(6, "R3 settle");
    chk(int'(count - held) < 6, 1, "R3 edges dropped");
    stb = 0;
    pulse(1, 5, "R3 open");
    held = count;
    pulse(1, 5, "R3 no strobe");
    chk(count, held, "R3 window closed without strobes");
    stb = 1; steps(4, "R3 strobes");
    pulse(1, 5, "R3 reopened");
    chk(count, held + 8'd1, "R3 accepted after window");

    // R4: long idle
    held = count;
    steps(600, "R4 idle");
    chk(count, held, "R4 holds");

    // R5: stop, load while stopped, stop/start together, load vs edge
    stop = 1; step("R5 stop");
    pulse(2, 6, "R5 stopped");
    chk(count, held, "R5 stop keeps count");
    lval = 8'h5A; load = 1; step("R5 load");
    chk(count, 8'h5A, "R5 load while stopped");
    start = 1; stop = 1; step("R5 both");
    pulse(2, 6, "R5 stop wins");
    chk(count, 8'h5A, "R5 stop wins over start");
    start = 1; step("R5 restart");
    test = 1; steps(2, "R5 edge");
    lval = 8'h10; load = 1; step("R5 load vs edge");
    chk(count, 8'h10, "R5 load wins");
    test = 0; steps(6, "R5 after");
    chk(count, 8'h10, "R5 edge lost");

    // R6: overflow with timer disabled latches, enabling presents
    lval = 8'hFE; load = 1; step("R6 load");
    pulse(2, 6, "R6"); pulse(2, 6, "R6");
    chk(count, 0, "R6 wrap");
    chk(irq, 0, "R6 masked");
    tien = 1; step("R6 enable");
    chk(vec, 7, "R6 vec7");
    // R9: ack clears timer
    ack = 1; step("R9 ack");
    chk(irq, 0, "R9 cleared");

    // R11: preload FF as second external interrupt
    lval = 8'hFF; load = 1; step("R11 load");
    pulse(2, 6, "R11");
    chk(vec, 7, "R11 vec7"); chk(irq, 1, "R11 irq");

    // R8: external wins, timer stays; R7 external vector
    ext = 1; eien = 1; step("R8 both");
    chk(vec, 3, "R8 ext wins");
    ack = 1; step("R9 ext ack");
    chk(vec, 3, "R7 ext vec");
    ext = 0; step("R8 ext gone");
    chk(vec, 7, "R8 timer kept");
    // R10: stop clears
    stop = 1; step("R10 stop");
    chk(irq, 0, "R10 cleared");
    chk(vec, 0, "R12 idle vec");

    // simultaneous overflow and external arrival
    start = 1; lval = 8'hFF; load = 1; step("R8 sim");
    test = 1; steps(2, "R8 sim");
    ext = 1; step("R8 sim");
    chk(vec, 3, "R8 same-cycle ext wins");
    ext = 0; step("R8 sim");
    chk(vec, 7, "R8 timer after");
    test = 0; ack = 1; step("R9 ack2");
    chk(irq, 0, "R12 idle irq");

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      stb   = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2) == 0) test = ~test;
      start = ($urandom_range(0, 60) == 0);
      stop  = ($urandom_range(0, 150) == 0);
      load  = ($urandom_range(0, 80) == 0);
      lval  = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
      if ($urandom_range(0, 40) == 0) ext  = ~ext;
      if ($urandom_range(0, 90) == 0) eien = ~eien;
      if ($urandom_range(0, 90) == 0) tien = ~tien;
      ack = irq && ($urandom_range(0, 3) == 0);
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare("R2 R3 R6 R8 R9 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule